// File: doc/BRIEF.md
# Variable-Latency Column Mixer

This unit takes one four-byte column of an AES state and returns that column after the forward column-mixing step. Each output byte is the XOR of the four input bytes, each multiplied by 1, 2 or 3 in GF(2^8). The field is reduced by the polynomial x^8+x^4+x^3+x+1. A column is accepted over a valid/ready handshake. The result comes back together with a one-cycle completion pulse.

The four input bytes are doubled one after another. Each doubling first takes a shift cycle. A second, separate reduction cycle follows only when the byte's top bit was 1. The time to finish a column therefore depends on its data, and that time is reported on a cycle-count output. This makes the unit useful wherever a data-dependent delay has to be measured or demonstrated.

Top module: `mc_colmix_vl`

## Requirements
- R1: While `rst` is high on a rising edge, the unit returns to idle. After that edge `in_ready` is 1 and `out_done` is 0.
- R2: A column is accepted on an edge where `in_valid` and `in_ready` are both 1. `in_ready` stays 0 from the next cycle until the cycle in which `out_done` is 1.
- R3: `out_done` is high for exactly one cycle per accepted column.
- R4: Input byte j sits at bits [8j+7:8j], and output byte i uses the same layout. With b = input bytes and 2·, 3· as field products, output byte i is 2·b[i] ^ 3·b[i+1] ^ b[i+2] ^ b[i+3], indices taken mod 4.
- R5: Doubling shifts the byte left by one bit. The result is then XORed with 0x1B only when the original top bit was 1, so doubling 0xD4 gives 0xB3 and doubling 0x54 gives 0xA8. Tripling is the doubled value XOR the byte.
- R6: The number of rising edges from the accepting edge to the edge that raises `out_done` is 5 plus the count of input bytes whose bit 7 is 1. `out_cycles` shows the same number while the result is valid.
- R7: `out_col` and `out_cycles` keep their values after `out_done` until the next completion.
- R8: `in_valid` and `in_col` are ignored while a column is in progress. The result and latency of the running column are unchanged, and no extra completion occurs.
- R9: A reset in the middle of a column abandons it. `out_col` and `out_cycles` return to 0 and no completion follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Column offered |
| in_ready | output | 1 | Unit idle and able to accept |
| in_col | input | 32 | Input column, byte j at [8j+7:8j] |
| out_done | output | 1 | One-cycle completion pulse |
| out_col | output | 32 | Mixed column, byte i at [8i+7:8i] |
| out_cycles | output | 4 | Cycles spent on the last completed column |

## Verification
The main function is tried with several kinds of columns:
- Columns with no byte above 0x7F show the base latency and the unreduced doubling path.
- Columns with every byte's top bit set show the longest latency and reduction in all four lanes.
- Mixed columns check that the latency counts only the bytes with the top bit set, and show whether the lane order or the rotation of coefficients is wrong.
- Single-byte columns such as 0xD4, 0x54 and 0x80 in a chosen position isolate the doubling and tripling of one byte.

Separate tests drive junk input while the unit is busy and apply a reset in the middle of a column.

// File: rtl/mc_col_pkg.sv
package mc_col_pkg;

    localparam int BYTE_W   = 8;
    localparam int LANES    = 4;
    localparam int COL_W    = BYTE_W * LANES;
    localparam int LANE_W   = $clog2(LANES);
    // one shift cycle per lane plus the finishing cycle
    localparam int LAT_BASE = LANES + 1;
    // every lane may add one reduction cycle
    localparam int LAT_MAX  = LAT_BASE + LANES;
    localparam int CNT_W    = $clog2(LAT_MAX + 1);

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SHIFT  = 2'd1,
        PH_FOLD   = 2'd2,
        PH_FINISH = 2'd3
    } mc_phase_e;

    typedef logic [LANES-1:0][BYTE_W-1:0] mc_col_t;

    typedef struct packed {
        mc_phase_e          phase;
        logic [LANE_W-1:0]  lane;
        mc_col_t            src;
        mc_col_t            dbl;
        logic [CNT_W-1:0]   cnt;
        mc_col_t            res;
        logic [CNT_W-1:0]   lat;
        logic               done;
    } mc_state_t;

endpackage

// File: rtl/mc_xtime_step.sv
// One step of field doubling: the shift and the reduction are offered
// separately so the sequencer can spend a cycle on each.
module mc_xtime_step #(
    parameter int               W    = 8,
    parameter logic [W-1:0]     POLY = 8'h1B
) (
    input  logic [W-1:0] data_i,
    output logic [W-1:0] shl_o,
    output logic         top_o,
    output logic [W-1:0] fold_o
);

    always_comb begin
        shl_o  = {data_i[W-2:0], 1'b0};
        top_o  = data_i[W-1];
        fold_o = data_i ^ POLY;
    end

endmodule

// File: rtl/mc_col_combine.sv
// Circulant combine: out[i] = 2*b[i] ^ 3*b[i+1] ^ b[i+2] ^ b[i+3],
// with 3*b written as dbl ^ b.
module mc_col_combine #(
    parameter int W = 8,
    parameter int L = 4
) (
    input  logic [L*W-1:0] src_i,
    input  logic [L*W-1:0] dbl_i,
    output logic [L*W-1:0] mix_o
);

    for (genvar i = 0; i < L; i++) begin : g_lane
        localparam int I1 = (i + 1) % L;
        localparam int I2 = (i + 2) % L;
        localparam int I3 = (i + 3) % L;
        assign mix_o[i*W +: W] = dbl_i[i*W +: W]
                               ^ dbl_i[I1*W +: W] ^ src_i[I1*W +: W]
                               ^ src_i[I2*W +: W]
                               ^ src_i[I3*W +: W];
    end

endmodule

// File: rtl/mc_colmix_vl.sv
module mc_colmix_vl
    import mc_col_pkg::*;
#(
    parameter logic [BYTE_W-1:0] FOLD_POLY = 8'h1B
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [COL_W-1:0] in_col,
    output logic             out_done,
    output logic [COL_W-1:0] out_col,
    output logic [CNT_W-1:0] out_cycles
);

    mc_state_t st_d, st_q;

    logic [BYTE_W-1:0] step_in_w;
    logic [BYTE_W-1:0] shl_w;
    logic [BYTE_W-1:0] fold_w;
    logic              top_w;
    logic              last_w;
    logic [COL_W-1:0]  mix_w;

    // the shift reads the original byte, the reduction reads the partial double
    assign step_in_w = (st_q.phase == PH_FOLD) ? st_q.dbl[st_q.lane]
                                               : st_q.src[st_q.lane];
    assign last_w    = (st_q.lane == LANE_W'(LANES - 1));

    mc_xtime_step #(
        .W    (BYTE_W),
        .POLY (FOLD_POLY)
    ) u_step (
        .data_i (step_in_w),
        .shl_o  (shl_w),
        .top_o  (top_w),
        .fold_o (fold_w)
    );

    mc_col_combine #(
        .W (BYTE_W),
        .L (LANES)
    ) u_comb (
        .src_i (st_q.src),
        .dbl_i (st_q.dbl),
        .mix_o (mix_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (in_valid) begin
                    st_d.src   = in_col;
                    st_d.dbl   = '0;
                    st_d.lane  = '0;
                    st_d.cnt   = CNT_W'(1);
                    st_d.phase = PH_SHIFT;
                end
            end
            PH_SHIFT: begin
                st_d.dbl[st_q.lane] = shl_w;
                st_d.cnt            = st_q.cnt + CNT_W'(1);
                if (top_w) begin
                    st_d.phase = PH_FOLD;
                end else if (last_w) begin
                    st_d.phase = PH_FINISH;
                end else begin
                    st_d.lane  = st_q.lane + LANE_W'(1);
                end
            end
            PH_FOLD: begin
                st_d.dbl[st_q.lane] = fold_w;
                st_d.cnt            = st_q.cnt + CNT_W'(1);
                if (last_w) begin
                    st_d.phase = PH_FINISH;
                end else begin
                    st_d.lane  = st_q.lane + LANE_W'(1);
                    st_d.phase = PH_SHIFT;
                end
            end
            PH_FINISH: begin
                st_d.res   = mix_w;
                st_d.lat   = st_q.cnt;
                st_d.done  = 1'b1;
                st_d.phase = PH_IDLE;
            end
            default: st_d.phase = PH_IDLE;
        endcase
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign in_ready   = (st_q.phase == PH_IDLE);
    assign out_done   = st_q.done;
    assign out_col    = st_q.res;
    assign out_cycles = st_q.lat;

    // R1: reset leaves the unit idle with no completion
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (in_ready && !out_done));

    // R2: an accepted column closes the input
    a_r2_accept_busy: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    // R3: completion lasts a single cycle
    a_r3_done_pulse: assert property (@(posedge clk) disable iff (rst)
        out_done |=> !out_done);

    // R6: reported latency lies between the base and the maximum
    a_r6_latency_range: assert property (@(posedge clk) disable iff (rst)
        out_done |-> (out_cycles >= CNT_W'(LAT_BASE) && out_cycles <= CNT_W'(LAT_MAX)));

    // R7: outputs change only together with a completion
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !st_d.done |=> ($stable(out_col) && $stable(out_cycles)));

endmodule

// File: tb/mc_colmix_vl_bench.sv
module mc_colmix_vl_bench;

    localparam int CLK_P    = 10;
    localparam int WD_LIMIT = 20000;
    localparam int NVEC     = 11;

    // {input column, expected output column}
    localparam logic [63:0] VECS [NVEC] = '{
        {32'h4553_13db, 32'hbca1_4d8e},
        {32'h5c22_0af2, 32'h9d58_dc9f},
        {32'h0101_0101, 32'h0101_0101},
        {32'hc6c6_c6c6, 32'hc6c6_c6c6},
        {32'hd5d4_d4d4, 32'hd6d7_d5d5},
        {32'h4c31_262d, 32'hf8bd_7e4d},
        {32'h0000_0000, 32'h0000_0000},
        {32'hffff_ffff, 32'hffff_ffff},
        {32'h0000_0080, 32'h9b80_801b},
        {32'hd400_0000, 32'hb367_d4d4},
        {32'h5400_0000, 32'ha8fc_5454}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_col = '0;
    logic        out_done;
    logic [31:0] out_col;
    logic [3:0]  out_cycles;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc++;

    mc_colmix_vl u_mc_colmix_vl (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_col     (in_col),
        .out_done   (out_done),
        .out_col    (out_col),
        .out_cycles (out_cycles)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int exp_lat(input logic [31:0] c);
        return 5 + int'(c[7]) + int'(c[15]) + int'(c[23]) + int'(c[31]);
    endfunction

    // Offer a column, optionally keep junk on the input for junk_cyc cycles,
    // and count edges until the completion pulse is seen.
    task automatic run_col(input logic [31:0] col, input int junk_cyc,
                           output logic [31:0] got, output int edges,
                           output int ready_bad);
        @(negedge clk);
        in_valid = 1'b1;
        in_col   = col;
        @(posedge clk);
        @(negedge clk);
        in_valid  = (junk_cyc > 0);
        in_col    = ~col;
        edges     = 0;
        ready_bad = 0;
        while (!out_done && edges < 40) begin
            if (in_ready) ready_bad++;
            @(posedge clk);
            edges++;
            @(negedge clk);
            if (edges >= junk_cyc) in_valid = 1'b0;
        end
        got = out_col;
    endtask

    initial begin
        wait (cyc >= WD_LIMIT);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WD_LIMIT);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] got;
        int          edges;
        int          rbad;
        logic [31:0] keep_col;
        logic [3:0]  keep_lat;
        int          seen;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1
        check(in_ready == 1'b1, "R1 ready after reset", 32'(in_ready), 32'd1);
        check(out_done == 1'b0, "R1 done after reset", 32'(out_done), 32'd0);

        // table walk: R4 / R5 results, R6 latency, R2 ready, R3 pulse
        for (int i = 0; i < NVEC; i++) begin
            logic [31:0] vin;
            logic [31:0] vexp;
            vin  = VECS[i][63:32];
            vexp = VECS[i][31:0];
            run_col(vin, 0, got, edges, rbad);
            if (i >= 9)
                check(got == vexp, "R5 doubling result", got, vexp);
            else
                check(got == vexp, "R4 mixed column", got, vexp);
            check(edges == exp_lat(vin), "R6 measured latency", 32'(edges), 32'(exp_lat(vin)));
            check(int'(out_cycles) == exp_lat(vin), "R6 out_cycles", 32'(out_cycles),
                  32'(exp_lat(vin)));
            check(rbad == 0, "R2 ready low while busy", 32'(rbad), 32'd0);
            @(posedge clk);
            @(negedge clk);
            check(out_done == 1'b0, "R3 done one cycle", 32'(out_done), 32'd0);
        end

        // R7: outputs hold while idle
        keep_col = out_col;
        keep_lat = out_cycles;
        repeat (6) @(posedge clk);
        @(negedge clk);
        check(out_col == keep_col, "R7 column held", out_col, keep_col);
        check(out_cycles == keep_lat, "R7 cycles held", 32'(out_cycles), 32'(keep_lat));
        check(out_done == 1'b0, "R7 no done while idle", 32'(out_done), 32'd0);

        // R8: junk on the input while busy is ignored
        run_col(VECS[0][63:32], 3, got, edges, rbad);
        check(got == VECS[0][31:0], "R8 result unaffected", got, VECS[0][31:0]);
        check(edges == exp_lat(VECS[0][63:32]), "R8 latency unaffected", 32'(edges),
              32'(exp_lat(VECS[0][63:32])));
        seen = 0;
        for (int k = 0; k < 12; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (out_done) seen++;
        end
        check(seen == 0, "R8 no extra completion", 32'(seen), 32'd0);

        // R9: reset in mid-column
        @(negedge clk);
        in_valid = 1'b1;
        in_col   = 32'hc6c6_c6c6;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(in_ready == 1'b1, "R9 idle after mid reset", 32'(in_ready), 32'd1);
        check(out_col == 32'd0, "R9 column cleared", out_col, 32'd0);
        check(out_cycles == 4'd0, "R9 cycles cleared", 32'(out_cycles), 32'd0);
        seen = 0;
        for (int k = 0; k < 12; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (out_done) seen++;
        end
        check(seen == 0, "R9 no completion after abort", 32'(seen), 32'd0);
        run_col(VECS[1][63:32], 0, got, edges, rbad);
        check(got == VECS[1][31:0], "R9 fresh column after reset", got, VECS[1][31:0]);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule